// File: doc/BRIEF.md
# Four-Function Eight-Bit ALU

A combinational arithmetic-logic unit that takes two operands and a two-bit function code and returns an 8-bit result. It also returns carry, signed-overflow and zero status. The datapath has two halves.

The arithmetic half sends either the second operand or its bitwise complement into a single ripple-carry adder. The low function bit picks which one, and it also gates the adder carry-in. Subtraction is therefore two's-complement addition through the same adder that performs addition. The logic half forms the bitwise AND and OR of the operands, and the low function bit picks one of them. The high function bit then chooses between the two halves.

The block has no clock and no state. A surrounding datapath drives the operands and the function code, and it reads the outputs once they have settled. The carry-in gate is a separate input. Holding it low turns the subtract code into A plus the one's complement of B.

Top module: `alu8_four_func`

## Requirements
- R1: With func_i = 2'b00, result_o equals a_i AND b_i, bit by bit.
- R2: With func_i = 2'b01, result_o equals a_i OR b_i, bit by bit.
- R3: With func_i = 2'b10, result_o equals (a_i + b_i) mod 256 and carry_o equals bit 8 of the 9-bit sum, whatever the value of cin_en_i.
- R4: With func_i = 2'b11 and cin_en_i = 1, result_o equals (a_i - b_i) mod 256. In this case carry_o is 1 exactly when a_i >= b_i as unsigned numbers, so a carry of 1 means no borrow.
- R5: With func_i = 2'b11 and cin_en_i = 0, the +1 is withheld: result_o equals (a_i + ~b_i) mod 256, and carry_o is bit 8 of that sum.
- R6: For func_i[1] = 1, ovf_o is 1 exactly when the two's-complement value of the adder sum lies outside -128..127. The sum in question is a_i plus the selected second operand plus the carry-in.
- R7: For func_i[1] = 0, carry_o and ovf_o are both 0.
- R8: zero_o is 1 exactly when all eight bits of result_o are 0, under every function code.
- R9: The outputs follow any change of a_i, b_i, func_i or cin_en_i with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| func_i | input | 2 | Function code: 00 AND, 01 OR, 10 add, 11 subtract |
| cin_en_i | input | 1 | Carry-in gate, ANDed with func_i[0] |
| result_o | output | 8 | Selected result |
| carry_o | output | 1 | Adder carry out (0 for logic functions) |
| ovf_o | output | 1 | Signed overflow (0 for logic functions) |
| zero_o | output | 1 | Result is all zeros |

## Verification
The four hand-worked vectors for add, subtract, AND and OR give one known answer per function code. The corner operands 0x00, 0xFF, 0x80 and 0x7F are paired in every combination under every code. These pairs separate carry from overflow: 0x7F+0x01 overflows without a carry, and 0xFF+0x01 carries without overflow. They also expose borrow at equality and at 0x00-0x01, and they drive the zero flag through AND, subtract-to-zero and wrapping add. Random operands with the carry gate on and off show that the gate changes subtraction by exactly one and leaves addition unchanged. A back-to-back sequence of input changes, with no clock edge between them, shows that the outputs follow the inputs combinationally.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    FN_AND = 2'b00,
    FN_OR  = 2'b01,
    FN_ADD = 2'b10,
    FN_SUB = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = x_i ^ y_i;
  assign s_o = p ^ c_i;
  assign c_o = (x_i & y_i) | (p & c_i);
endmodule

// File: rtl/alu_math_unit.sv
module alu_math_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic             cin_en_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_inv;
  logic [WIDTH-1:0] b_op;
  logic [WIDTH:0]   carry;

  // inverter bank and operand selector
  for (genvar i = 0; i < WIDTH; i++) begin : g_inv
    assign b_inv[i] = ~b_i[i];
    assign b_op[i]  = sub_i ? b_inv[i] : b_i[i];
  end

  assign carry[0] = cin_en_i & sub_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rca
    alu_full_adder u_fa (
      .x_i (a_i[i]),
      .y_i (b_op[i]),
      .c_i (carry[i]),
      .s_o (sum_o[i]),
      .c_o (carry[i+1])
    );
  end

  assign cout_o = carry[WIDTH];
  // same-sign operands, different-sign result
  assign ovf_o  = (a_i[MSB] ~^ b_op[MSB]) & (sum_o[MSB] ^ a_i[MSB]);
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             or_sel_i,
  output logic [WIDTH-1:0] res_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic and_b, or_b;
    assign and_b    = a_i[i] & b_i[i];
    assign or_b     = a_i[i] | b_i[i];
    assign res_o[i] = or_sel_i ? or_b : and_b;
  end
endmodule

// File: rtl/alu8_four_func.sv
module alu8_four_func #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       func_i,
  input  logic             cin_en_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);
  import alu_pkg::*;

  alu_fn_e          fn;
  logic             math_sel, lo_sel;
  logic [WIDTH-1:0] math_res, logic_res;
  logic             math_cout, math_ovf;

  assign fn       = alu_fn_e'(func_i);
  assign math_sel = fn[1];
  assign lo_sel   = fn[0];

  alu_math_unit #(.WIDTH(WIDTH)) u_math (
    .a_i      (a_i),
    .b_i      (b_i),
    .sub_i    (lo_sel),
    .cin_en_i (cin_en_i),
    .sum_o    (math_res),
    .cout_o   (math_cout),
    .ovf_o    (math_ovf)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i      (a_i),
    .b_i      (b_i),
    .or_sel_i (lo_sel),
    .res_o    (logic_res)
  );

  assign result_o = math_sel ? math_res : logic_res;
  assign carry_o  = math_sel & math_cout;
  assign ovf_o    = math_sel & math_ovf;
  assign zero_o   = ~|result_o;
endmodule

module alu8_checker #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       func_i,
  input logic             cin_en_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o
);
  logic [WIDTH:0] ref_add, ref_sub;
  assign ref_add = {1'b0, a_i} + {1'b0, b_i};
  assign ref_sub = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, cin_en_i};

  always_comb begin
    if (func_i == 2'b00)
      a_r1_and_bits: assert ((result_o & ~(a_i & b_i)) == '0 && ((a_i & b_i) & ~result_o) == '0);
    if (func_i == 2'b01)
      a_r2_or_bits: assert ((result_o & ~(a_i | b_i)) == '0 && ((a_i | b_i) & ~result_o) == '0);
    if (func_i == 2'b10)
      a_r3_add_sum: assert ({carry_o, result_o} == ref_add);
    if (func_i == 2'b11 && cin_en_i)
      a_r4_sub_borrow: assert (carry_o == (a_i >= b_i));
    if (func_i == 2'b11)
      a_r5_sub_sum: assert ({carry_o, result_o} == ref_sub);
    if (!func_i[1])
      a_r7_logic_flags: assert (!carry_o && !ovf_o);
    a_r8_zero_flag: assert (zero_o == (result_o == '0));
  end
endmodule

bind alu8_four_func alu8_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_alu8_four_func.sv
module tb_alu8_four_func;
  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic [1:0] f;
  logic       cen;
  logic [7:0] res;
  logic       co, ov, zf;
  int         checks = 0;
  int         failures = 0;
  int         cyc = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  alu8_four_func dut (
    .a_i(a), .b_i(b), .func_i(f), .cin_en_i(cen),
    .result_o(res), .carry_o(co), .ovf_o(ov), .zero_o(zf)
  );

  // behavioural reference: {carry, ovf, zero, result}
  function automatic logic [10:0] model(input logic [7:0] x, y, input logic [1:0] fn,
                                        input logic ce);
    int ua, ub, ci, s, sa, sb, ss;
    logic [7:0] r;
    logic c, o;
    c = 0; o = 0;
    if (!fn[1]) begin
      r = fn[0] ? (x | y) : (x & y);
    end else begin
      ua = int'(x);
      ub = fn[0] ? (255 - int'(y)) : int'(y);
      ci = (fn[0] && ce) ? 1 : 0;
      s  = ua + ub + ci;
      r  = s[7:0];
      c  = (s > 255);
      sa = (ua > 127) ? ua - 256 : ua;
      sb = (ub > 127) ? ub - 256 : ub;
      ss = sa + sb + ci;
      o  = (ss > 127) || (ss < -128);
    end
    return {c, o, (r == 8'h00), r};
  endfunction

  task automatic apply(input logic [7:0] x, y, input logic [1:0] fn, input logic ce);
    @(negedge clk);
    a = x; b = y; f = fn; cen = ce;
    #1;
  endtask

  task automatic compare(input string req);
    logic [10:0] e;
    e = model(a, b, f, cen);
    checks++;
    if ({co, ov, zf, res} !== e) begin
      failures++;
      $display("FAIL %s a=%h b=%h f=%b cen=%b: got c=%b v=%b z=%b r=%h exp c=%b v=%b z=%b r=%h",
               req, a, b, f, cen, co, ov, zf, res, e[10], e[9], e[8], e[7:0]);
    end
  endtask

  task automatic expect_val(input string req, input logic [10:0] e);
    checks++;
    if ({co, ov, zf, res} !== e) begin
      failures++;
      $display("FAIL %s got %b expected %b", req, {co, ov, zf, res}, e);
    end
  endtask

  task automatic t_initial;
    apply(8'h00, 8'h00, 2'b00, 1'b1);
    expect_val("R8 initial all-zero inputs", {1'b0, 1'b0, 1'b1, 8'h00});
  endtask

  task automatic t_worked_vectors;
    apply(8'h61, 8'h57, 2'b10, 1'b1);
    expect_val("R3 R6 add vector", {1'b0, 1'b1, 1'b0, 8'hB8});
    apply(8'hB5, 8'h3E, 2'b11, 1'b1);
    expect_val("R4 R6 sub vector", {1'b1, 1'b1, 1'b0, 8'h77});
    apply(8'hC2, 8'h6D, 2'b00, 1'b1);
    expect_val("R1 and vector", {1'b0, 1'b0, 1'b0, 8'h40});
    apply(8'hC2, 8'h61, 2'b01, 1'b1);
    expect_val("R2 or vector", {1'b0, 1'b0, 1'b0, 8'hE3});
  endtask

  task automatic t_corner_sweep;
    logic [7:0] cv [4] = '{8'h00, 8'hFF, 8'h80, 8'h7F};
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++) begin
          apply(cv[i], cv[j], k[1:0], 1'b1);
          compare("R1 R2 R3 R4 R6 R7 R8 corners");
        end
    apply(8'h7F, 8'h01, 2'b10, 1'b1);
    expect_val("R6 add overflow no carry", {1'b0, 1'b1, 1'b0, 8'h80});
    apply(8'hFF, 8'h01, 2'b10, 1'b1);
    expect_val("R3 R8 add carry wraps to zero", {1'b1, 1'b0, 1'b1, 8'h00});
    apply(8'h00, 8'h01, 2'b11, 1'b1);
    expect_val("R4 borrow 0-1", {1'b0, 1'b0, 1'b0, 8'hFF});
    apply(8'h5A, 8'h5A, 2'b11, 1'b1);
    expect_val("R4 R8 equal operands", {1'b1, 1'b0, 1'b1, 8'h00});
  endtask

  task automatic t_carry_gate;
    apply(8'h10, 8'h03, 2'b11, 1'b0);
    expect_val("R5 gated carry", {1'b1, 1'b0, 1'b0, 8'h0C});
    apply(8'h40, 8'h30, 2'b10, 1'b0);
    expect_val("R3 add ignores cin_en", {1'b0, 1'b0, 1'b0, 8'h70});
    for (int n = 0; n < 200; n++) begin
      logic [7:0] x, y;
      x = 8'($urandom());
      y = 8'($urandom());
      apply(x, y, 2'b11, 1'b0);
      compare("R5 R6 random sub no carry-in");
      apply(x, y, 2'b10, 1'b0);
      compare("R3 random add cin_en low");
    end
  endtask

  task automatic t_random;
    for (int n = 0; n < 400; n++) begin
      apply(8'($urandom()), 8'($urandom()), 2'($urandom()), 1'b1);
      compare("R1 R2 R3 R4 R6 R7 R8 random");
    end
  endtask

  task automatic t_no_clock;
    // R9: several changes between two clock edges
    @(posedge clk);
    #0.5;
    a = 8'h0F; b = 8'hF0; f = 2'b01; cen = 1'b1;
    #0.5;
    expect_val("R9 comb step1", {1'b0, 1'b0, 1'b0, 8'hFF});
    f = 2'b00;
    #0.5;
    expect_val("R9 comb step2", {1'b0, 1'b0, 1'b1, 8'h00});
    f = 2'b10;
    #0.5;
    expect_val("R9 comb step3", {1'b0, 1'b0, 1'b0, 8'hFF});
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; f = '0; cen = 1'b1;
    t_initial();
    t_worked_vectors();
    t_corner_sweep();
    t_carry_gate();
    t_random();
    t_no_clock();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule